// File: doc/BRIEF.md
# Wakeup Interrupt Polarity Normalizer

This block takes a set of raw interrupt lines and converts each one into a form that a downstream interrupt controller can accept. That controller only understands active-high levels and rising edges. Each line has a 3-bit trigger code and an enable bit. A level line that is active low is inverted. A falling-edge line produces a one-cycle pulse when its input falls. A dual-edge line produces a one-cycle pulse on every transition of its input. Each input first passes through a two-flop synchronizer. Edges are found by comparing the synchronized value with a registered copy of it.

A word-addressed register port sets up the block. Enable bits are packed 32 to a word in a bank that starts at byte offset 0x10. Each line also has its own configuration word, starting at byte offset 0x110. Whenever a write changes a line's stored code, the block raises a one-cycle flag for that line. The downstream side can use the flag to discard a pending state that the reconfiguration may have caused.

Top module: `wake_polarity_norm`

## Requirements
- R1: After a synchronous reset, all enables read 0, all trigger codes read 000, and `line_out` and `cfg_changed` are all low.
- R2: With code 100, an enabled line's output follows its input level. A change on `raw_in` appears on `line_out` three clock edges later.
- R3: With code 000, an enabled line's output is the inverse of its input level, with the same three-edge latency.
- R4: With code 110, an enabled line gives a single-cycle high pulse when its input rises. A fall gives no pulse.
- R5: With code 010, an enabled line gives a single-cycle high pulse when its input falls. A rise gives no pulse.
- R6: With code 111, an enabled line gives a single-cycle high pulse on every rise and every fall of its input.
- R7: Codes 001, 011 and 101 act as disabled: the output stays low for any input.
- R8: The enable for line n is bit n%32 of the word at byte address 0x10 + 4*(n/32). A line whose enable is 0 holds its output low.
- R9: The code for line n is bits [2:0] of the word at byte address 0x110 + 4*n. Only those 3 bits are stored, and the upper bits read back as 0. Read data appears one cycle after `reg_rd`.
- R10: A write to line n's configuration word that changes its stored code pulses `cfg_changed[n]` for one cycle. A write of the same code gives no pulse, and at most one flag is high at a time.
- R11: Enabling a line while its input is held steady produces no edge pulse.
- R12: The block ignores misaligned addresses, unmapped addresses and enable bits above the last line. Reads of any of these return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | NUM_LINES | Raw asynchronous interrupt inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data, 0 when no read |
| line_out | output | NUM_LINES | Normalized active-high level or rising pulse per line |
| cfg_changed | output | NUM_LINES | One-cycle flag: stored code of that line changed |

## Verification
Line results are due at the third rising edge after an input change. The bench drives `raw_in` on a falling edge, waits three falling edges, and then samples the pulse cycle. One falling edge later it samples the settled value, where edge codes must have returned low. Register effects are due at the edge that takes the strobe: `cfg_changed` is sampled at the falling edge just after a write. Read data is sampled one falling edge after `reg_rd` is raised. Inputs are held still around every configuration change, so no stale edge can fall inside a sampled cycle.

// File: rtl/wpn_pkg.sv
package wpn_pkg;
  typedef enum logic [2:0] {
    TRIG_LVL_LOW  = 3'b000,
    TRIG_FALL     = 3'b010,
    TRIG_LVL_HIGH = 3'b100,
    TRIG_RISE     = 3'b110,
    TRIG_BOTH     = 3'b111
  } trig_e;

  localparam int WORD_W       = 32;
  localparam int LINES_PER_EN = 32;
  localparam int EN_BASE_B    = 'h010;
  localparam int CFG_BASE_B   = 'h110;
  localparam int MAX_LINES    = 256;
endpackage

// File: rtl/wpn_regfile.sv
module wpn_regfile
  import wpn_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int ADDR_W    = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [WORD_W-1:0]      reg_wdata,
  output logic [WORD_W-1:0]      reg_rdata,
  output logic [NUM_LINES-1:0]   en_o,
  output logic [3*NUM_LINES-1:0] code_o,
  output logic [NUM_LINES-1:0]   chg_o
);
  localparam int NB     = (NUM_LINES + LINES_PER_EN - 1) / LINES_PER_EN;
  localparam int WIDX_W = ADDR_W - 2;
  localparam logic [WIDX_W-1:0] EN_LO  = WIDX_W'(EN_BASE_B / 4);
  localparam logic [WIDX_W-1:0] EN_HI  = WIDX_W'(EN_BASE_B / 4 + NB);
  localparam logic [WIDX_W-1:0] CFG_LO = WIDX_W'(CFG_BASE_B / 4);
  localparam logic [WIDX_W-1:0] CFG_HI = WIDX_W'(CFG_BASE_B / 4 + NUM_LINES);

  logic [WIDX_W-1:0] widx, bank_idx, line_idx;
  logic              aligned, hit_en, hit_cfg;
  logic [2:0]        cfg_q [NUM_LINES];
  logic [WORD_W-1:0] rd_word;

  assign widx     = reg_addr[ADDR_W-1:2];
  assign aligned  = (reg_addr[1:0] == 2'b00);
  assign hit_en   = aligned && (widx >= EN_LO) && (widx < EN_HI);
  assign hit_cfg  = aligned && (widx >= CFG_LO) && (widx < CFG_HI);
  assign bank_idx = widx - EN_LO;
  assign line_idx = widx - CFG_LO;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o      <= '0;
      chg_o     <= '0;
      reg_rdata <= '0;
      for (int n = 0; n < NUM_LINES; n++) cfg_q[n] <= 3'b000;
    end else begin
      for (int n = 0; n < NUM_LINES; n++) begin
        if (reg_wr && hit_en && bank_idx == WIDX_W'(n / LINES_PER_EN))
          en_o[n] <= reg_wdata[n % LINES_PER_EN];
        chg_o[n] <= 1'b0;
        if (reg_wr && hit_cfg && line_idx == WIDX_W'(n)) begin
          cfg_q[n] <= reg_wdata[2:0];
          chg_o[n] <= (reg_wdata[2:0] != cfg_q[n]);
        end
      end
      reg_rdata <= reg_rd ? rd_word : '0;
    end
  end

  always_comb begin
    rd_word = '0;
    if (hit_en) begin
      for (int n = 0; n < NUM_LINES; n++)
        if (bank_idx == WIDX_W'(n / LINES_PER_EN)) rd_word[n % LINES_PER_EN] = en_o[n];
    end else if (hit_cfg) begin
      for (int n = 0; n < NUM_LINES; n++)
        if (line_idx == WIDX_W'(n)) rd_word = {{(WORD_W-3){1'b0}}, cfg_q[n]};
    end
  end

  always_comb begin
    for (int n = 0; n < NUM_LINES; n++) code_o[3*n +: 3] = cfg_q[n];
  end

  // R10: a single configuration write touches one line only
  a_r10_flag_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chg_o));

  // R10: a change flag only follows a write strobe
  a_r10_flag_from_write: assert property (@(posedge clk) disable iff (rst)
    (|chg_o) |-> $past(reg_wr));
endmodule

// File: rtl/wpn_line.sv
module wpn_line
  import wpn_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       raw_i,
  input  logic       en_i,
  input  logic [2:0] code_i,
  output logic       out_o
);
  logic meta_q, sync_q, hist_q, norm;

  always_comb begin
    case (code_i)
      TRIG_LVL_LOW:  norm = ~sync_q;
      TRIG_FALL:     norm = ~sync_q & hist_q;
      TRIG_LVL_HIGH: norm = sync_q;
      TRIG_RISE:     norm = sync_q & ~hist_q;
      TRIG_BOTH:     norm = sync_q ^ hist_q;
      default:       norm = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      hist_q <= 1'b0;
      out_o  <= 1'b0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      hist_q <= sync_q;
      out_o  <= en_i & norm;
    end
  end

  // R8: a disabled line is silent in the following cycle
  a_r8_disabled_low: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !out_o);

  // R7: unlisted codes never drive the output
  a_r7_unlisted_quiet: assert property (@(posedge clk) disable iff (rst)
    (code_i == 3'b001 || code_i == 3'b011 || code_i == 3'b101) |=> !out_o);

  // R4: a rising-edge pulse never lasts two cycles
  a_r4_rise_single: assert property (@(posedge clk) disable iff (rst)
    (out_o && $past(code_i) == TRIG_RISE && $past(en_i) && code_i == TRIG_RISE)
      |=> !out_o);
endmodule

// File: rtl/wake_polarity_norm.sv
module wake_polarity_norm
  import wpn_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] raw_in,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [NUM_LINES-1:0] line_out,
  output logic [NUM_LINES-1:0] cfg_changed
);
  logic [NUM_LINES-1:0]   en_vec;
  logic [3*NUM_LINES-1:0] code_vec;

  initial begin
    if (NUM_LINES < 1 || NUM_LINES > MAX_LINES)
      $error("NUM_LINES out of range");
  end

  wpn_regfile #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .en_o(en_vec), .code_o(code_vec), .chg_o(cfg_changed)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    wpn_line u_line (
      .clk(clk), .rst(rst),
      .raw_i(raw_in[g]), .en_i(en_vec[g]),
      .code_i(code_vec[3*g +: 3]), .out_o(line_out[g])
    );
  end
endmodule

// File: tb/wake_polarity_norm_test.sv
`timescale 1ns/1ps
module wake_polarity_norm_test;
  localparam int N = 40;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  raw_in = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [N-1:0]  line_out, cfg_changed;

  int total = 0, bad = 0;
  bit done = 0;

  wake_polarity_norm #(.NUM_LINES(N), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .raw_in(raw_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .line_out(line_out), .cfg_changed(cfg_changed)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(addr); reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = AW'(addr);
    @(negedge clk);
    reg_rd = 1'b0;
    data = reg_rdata;
  endtask

  function automatic logic [N-1:0] model(input logic [2:0] c, input logic [N-1:0] en,
                                         input logic [N-1:0] cur, input logic [N-1:0] prv);
    case (c)
      3'b000:  return en & ~cur;
      3'b010:  return en & ~cur & prv;
      3'b100:  return en & cur;
      3'b110:  return en & cur & ~prv;
      3'b111:  return en & (cur ^ prv);
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'b000:  return "R3 R8";
      3'b010:  return "R5 R8";
      3'b100:  return "R2 R8";
      3'b110:  return "R4 R8";
      3'b111:  return "R6 R8";
      default: return "R7";
    endcase
  endfunction

  logic [N-1:0] cur_m = '0;

  // drive a new input vector; check pulse cycle and settled cycle
  task automatic apply(input logic [N-1:0] nv, input logic [2:0] c, input logic [N-1:0] en);
    logic [N-1:0] prv;
    prv = cur_m;
    @(negedge clk);
    raw_in = nv;
    cur_m = nv;
    repeat (3) @(negedge clk);
    check({tag_of(c), " pulse"}, 64'(line_out), 64'(model(c, en, nv, prv)));
    @(negedge clk);
    check({tag_of(c), " settle"}, 64'(line_out), 64'(model(c, en, nv, nv)));
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [2:0]  old_code;
    logic [N-1:0] en_pat;
    logic [N-1:0] pats [8];
    pats[0] = '1;                 pats[1] = '0;
    pats[2] = 40'h55_5555_5555;   pats[3] = 40'hAA_AAAA_AAAA;
    pats[4] = 40'h0F_3C96_E1D2;   pats[5] = ~40'h0F_3C96_E1D2;
    pats[6] = 40'h0F_3C96_E1D2;   pats[7] = '0;
    en_pat = 40'hC3_F0F5_A69F;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 out", 64'(line_out), 64'h0);
    check("R1 chg", 64'(cfg_changed), 64'h0);
    rd('h10, d);  check("R1 en bank0", 64'(d), 64'h0);
    rd('h14, d);  check("R1 en bank1", 64'(d), 64'h0);
    rd('h110 + 4*7, d); check("R1 cfg7", 64'(d), 64'h0);
    // R12: unmapped and misaligned
    wr('h12, 32'hFFFF_FFFF);
    rd('h10, d);  check("R12 misaligned write ignored", 64'(d), 64'h0);
    rd('h00, d);  check("R12 unmapped rd", 64'(d), 64'h0);
    rd('h100, d); check("R12 unmapped rd2", 64'(d), 64'h0);
    rd('h110 + 4*N, d); check("R12 beyond last cfg", 64'(d), 64'h0);

    // enables: bank1 upper bits lie beyond the last line
    wr('h10, en_pat[31:0]);
    wr('h14, {24'hFF_FFFF, en_pat[39:32]});
    rd('h10, d); check("R8 en bank0", 64'(d), 64'(en_pat[31:0]));
    rd('h14, d); check("R12 R8 en bank1", 64'(d), 64'({24'h0, en_pat[39:32]}));

    old_code = 3'b000;
    for (int c = 0; c < 8; c++) begin
      for (int n = 0; n < N; n++) begin
        wr('h110 + 4*n, 32'hDEAD_BEE8 | 32'(c));
        // R10: flag exactly when stored code changes
        check("R10 chg", 64'(cfg_changed),
              (3'(c) != old_code) ? (64'h1 << n) : 64'h0);
      end
      @(negedge clk);
      check("R10 chg clears", 64'(cfg_changed), 64'h0);
      rd('h110, d);           check("R9 cfg0", 64'(d), 64'(c));
      rd('h110 + 4*(N-1), d); check("R9 cfg last", 64'(d), 64'(c));
      old_code = 3'(c);
      repeat (4) @(negedge clk);
      for (int p = 0; p < 8; p++) apply(pats[p], 3'(c), en_pat);
    end

    // R10: same code rewritten gives no flag
    wr('h110 + 4*3, 32'h7);
    check("R10 same code", 64'(cfg_changed), 64'h0);

    // R11: enable rising lines with input held high
    for (int n = 0; n < N; n++) wr('h110 + 4*n, 32'h6);
    wr('h10, 32'h0); wr('h14, 32'h0);
    apply('1, 3'b110, '0);
    wr('h10, 32'hFFFF_FFFF); wr('h14, 32'hFF);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R11 no false edge", 64'(line_out), 64'h0);
    end
    apply('0, 3'b110, '1);
    apply('1, 3'b110, '1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule